// File: doc/BRIEF.md
# GPIO Bank with Indirect Pin Configuration

This block gives a host 29 general-purpose pins. The pins are grouped into four 8-bit ports that sit behind a 16-byte register window. Each port has a data-out register and a data-in register, both readable. The two low ports also carry rising-edge event detection, with an enable register and a write-one-to-clear status register.

Per-pin drive settings do not have one register per pin. The host first writes a pin selector, encoded as port in bits 5:4 and bit in bits 2:0. It then reads or writes a single configuration byte that belongs to the selected pin.

Each pin can be:
- an input,
- a push-pull output,
- an open-drain output, with the pad enabled only while the data bit is low.

Its pull-up control can be set independently of the drive mode. Pending enabled events are combined onto one event output.

Top module: `gpx_bank`

## Requirements
- R1: After reset, every register reads 0x00, `pad_oe`, `pad_out` and `pad_pu` are all zero, and `evt_irq` is 0.
- R2: Data-out registers sit at offsets 0x00 (port 0), 0x04 (port 1), 0x08 (port 2) and 0x0A (port 3). A written value reads back at the same offset. Pin n is driven from bit n%8 of port n/8.
- R3: Data-in registers sit at offsets 0x01, 0x05, 0x09 and 0x0B. They return the pad level through a two-flop synchronizer, so a pad change becomes readable after two rising clock edges and not after one. Port 3 bits 7:5, which have no pin, read 0.
- R4: The pin select register at 0x0E holds the written byte, which encodes (port << 4) | bit. The configuration register at 0x0F reads the selected pin's settings: bit 0 output enable, bit 1 push-pull (0 = open-drain), bit 2 pull-up. Bits 7:3 read 0.
- R5: A selector names no pin when bit 3 is set, when bits 7:6 are nonzero, or when it decodes to pin 29 or higher. With such a selector, 0x0F reads 0x00 and writes to 0x0F change no pin.
- R6: In push-pull mode with output enable set, `pad_oe` is 1 and `pad_out` follows the data-out bit.
- R7: In open-drain mode with output enable set, `pad_out` is 0 and `pad_oe` is 1 only while the data-out bit is 0. With output enable clear, `pad_oe` is 0.
- R8: `pad_pu` for a pin equals that pin's configuration bit 2, regardless of its other bits.
- R9: Event enable registers sit at 0x02 and 0x06, and event status registers at 0x03 and 0x07, for ports 0 and 1. A status bit sets on a rising edge of the synchronized input when its enable bit is 1, and never when the enable bit is 0.
- R10: Writing 1 to a status bit clears it, and bits written 0 are unchanged. If a new rising edge arrives in the same cycle as the clear, the bit stays set.
- R11: `evt_irq` is 1 exactly when some status bit is set and its enable bit is also set.
- R12: Offsets 0x0C and 0x0D read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe, taken at the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pad_in | input | 29 | Pad input levels |
| pad_out | output | 29 | Pad output values |
| pad_oe | output | 29 | Pad output enables |
| pad_pu | output | 29 | Pull-up controls |
| evt_irq | output | 1 | Any enabled event pending |

## Verification
The event status register is updated by two sources: a rising edge on a pin, and a write-one-to-clear from the host. These two can land on the same clock edge.

The bench sets a status bit, drops the pin, and raises it again. It then issues the clear at exactly the edge where the synchronized rise is seen, which is the third edge after the pad change. The status bit must still read 1 afterwards, and a later clear with no edge present must bring it to 0.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int BYTE_W    = 8;
    localparam int EVT_PORTS = 2;
    localparam logic [3:0] OFF_SEL = 4'hE;
    localparam logic [3:0] OFF_CFG = 4'hF;

    typedef struct packed {
        logic pull_up;    // bit 2
        logic push_pull;  // bit 1
        logic out_en;     // bit 0
    } pin_cfg_t;

    // Ports with event logic take four registers, the others two.
    function automatic logic [3:0] off_dout(input int p);
        if (p < EVT_PORTS) return 4'(p * 4);
        return 4'(EVT_PORTS * 4 + (p - EVT_PORTS) * 2);
    endfunction

    function automatic logic [3:0] off_din(input int p);
        return off_dout(p) + 4'd1;
    endfunction

    function automatic logic [3:0] off_en(input int p);
        return 4'(p * 4 + 2);
    endfunction

    function automatic logic [3:0] off_st(input int p);
        return 4'(p * 4 + 3);
    endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W = 29
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.s2;
endmodule

// File: rtl/gpx_evt.sv
module gpx_evt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] st_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] stat;
    } evt_t;

    evt_t ev_d, ev_q;
    logic [W-1:0] rise;

    always_comb begin
        rise      = lvl_i & ~ev_q.prev;
        ev_d.prev = lvl_i;
        // a fresh edge outranks a clear in the same cycle
        ev_d.stat = (ev_q.stat & ~clr_i) | (rise & en_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign st_o   = ev_q.stat;
    assign pend_o = |(ev_q.stat & en_i);

    // R9: a bit that was clear with its enable off stays clear
    a_r9_no_set_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ev_q.stat & ~$past(ev_q.stat) & ~$past(en_i)) == '0));

    // R10: cleared bits drop when no edge coincides
    a_r10_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (rise == '0) |=> ((ev_q.stat & $past(clr_i)) == '0));
endmodule

// File: rtl/gpx_pincfg.sv
module gpx_pincfg
    import gpx_pkg::*;
#(
    parameter int NUM_PINS = 29
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_wr_i,
    input  logic                cfg_wr_i,
    input  logic [BYTE_W-1:0]   wdata_i,
    input  logic [NUM_PINS-1:0] dout_i,
    output logic [BYTE_W-1:0]   sel_o,
    output logic [BYTE_W-1:0]   cfg_rd_o,
    output logic [NUM_PINS-1:0] pad_out_o,
    output logic [NUM_PINS-1:0] pad_oe_o,
    output logic [NUM_PINS-1:0] pad_pu_o
);
    localparam int IDX_W = 5;

    typedef struct packed {
        logic [BYTE_W-1:0]          sel;
        pin_cfg_t [NUM_PINS-1:0]    cfg;
    } pc_t;

    pc_t pc_d, pc_q;
    logic [IDX_W-1:0] idx;
    logic             sel_ok;

    always_comb begin
        idx    = {pc_q.sel[5:4], pc_q.sel[2:0]};
        sel_ok = (pc_q.sel[7:6] == 2'b00) && !pc_q.sel[3]
                 && (int'(idx) < NUM_PINS);
        pc_d = pc_q;
        if (sel_wr_i) pc_d.sel = wdata_i;
        if (cfg_wr_i && sel_ok) pc_d.cfg[idx] = wdata_i[2:0];
        cfg_rd_o = sel_ok ? {5'b0, pc_q.cfg[idx]} : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign sel_o = pc_q.sel;

    logic [NUM_PINS-1:0] pp_vec;
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pad
        assign pp_vec[n]    = pc_q.cfg[n].push_pull;
        assign pad_oe_o[n]  = pc_q.cfg[n].out_en & (pc_q.cfg[n].push_pull | ~dout_i[n]);
        assign pad_out_o[n] = pc_q.cfg[n].push_pull & dout_i[n];
        assign pad_pu_o[n]  = pc_q.cfg[n].pull_up;
    end

    // R5: writes through a selector that names no pin leave every pin alone
    a_r5_bad_sel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && !sel_ok) |=> $stable(pc_q.cfg));

    // R7: an open-drain pad is never enabled while its data bit is high
    a_r7_open_drain_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe_o & ~pp_vec & dout_i) == '0));
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
    import gpx_pkg::*;
#(
    parameter int NUM_PINS = 29
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          reg_addr,
    input  logic                reg_wr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pu,
    output logic                evt_irq
);
    localparam int NUM_PORTS = (NUM_PINS + BYTE_W - 1) / BYTE_W;
    localparam int FLAT_W    = NUM_PORTS * BYTE_W;

    typedef struct packed {
        logic [NUM_PORTS-1:0][BYTE_W-1:0] dout;
        logic [EVT_PORTS-1:0][BYTE_W-1:0] en;
    } bank_t;

    bank_t bk_d, bk_q;

    logic [NUM_PINS-1:0]              lvl;
    logic [NUM_PORTS-1:0][BYTE_W-1:0] din_pk;
    logic [EVT_PORTS-1:0][BYTE_W-1:0] clr, st;
    logic [EVT_PORTS-1:0]             pend;
    logic [NUM_PINS-1:0]              dout_pins;
    logic [BYTE_W-1:0]                sel_rd, cfg_rd;
    logic                             sel_wr, cfg_wr;

    gpx_sync #(.W(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pad_in), .lvl_o(lvl)
    );

    assign din_pk    = FLAT_W'(lvl);
    assign dout_pins = NUM_PINS'(bk_q.dout);

    for (genvar p = 0; p < EVT_PORTS; p++) begin : g_evt
        gpx_evt #(.W(BYTE_W)) u_evt (
            .clk(clk), .rst_n(rst_n),
            .lvl_i(din_pk[p]), .en_i(bk_q.en[p]), .clr_i(clr[p]),
            .st_o(st[p]), .pend_o(pend[p])
        );
    end

    assign evt_irq = |pend;
    assign sel_wr  = reg_wr && (reg_addr == OFF_SEL);
    assign cfg_wr  = reg_wr && (reg_addr == OFF_CFG);

    gpx_pincfg #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .sel_wr_i(sel_wr), .cfg_wr_i(cfg_wr), .wdata_i(reg_wdata),
        .dout_i(dout_pins), .sel_o(sel_rd), .cfg_rd_o(cfg_rd),
        .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pu_o(pad_pu)
    );

    always_comb begin
        bk_d      = bk_q;
        reg_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (reg_wr && reg_addr == off_dout(p)) bk_d.dout[p] = reg_wdata;
            if (reg_addr == off_dout(p)) reg_rdata = bk_q.dout[p];
            if (reg_addr == off_din(p))  reg_rdata = din_pk[p];
        end
        for (int p = 0; p < EVT_PORTS; p++) begin
            clr[p] = (reg_wr && reg_addr == off_st(p)) ? reg_wdata : '0;
            if (reg_wr && reg_addr == off_en(p)) bk_d.en[p] = reg_wdata;
            if (reg_addr == off_en(p)) reg_rdata = bk_q.en[p];
            if (reg_addr == off_st(p)) reg_rdata = st[p];
        end
        if (reg_addr == OFF_SEL) reg_rdata = sel_rd;
        if (reg_addr == OFF_CFG) reg_rdata = cfg_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    // R2: a write to port 0 data out is held in the next cycle
    a_r2_dout_holds_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == off_dout(0)) |=> (bk_q.dout[0] == $past(reg_wdata)));

    // R11: the event output only rises when some enable is set
    a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        evt_irq |-> (bk_q.en != '0));
endmodule

// File: tb/gpx_bank_test.sv
`timescale 1ns/1ps
module gpx_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [28:0] pad_in = '0;
    logic [28:0] pad_out, pad_oe, pad_pu;
    logic        evt_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpx_bank uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .evt_irq(evt_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, {24'b0, v}, {24'b0, exp});
    endtask

    task automatic set_pads(input logic [28:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 16; a++) rd_chk("R1 reg after reset", 4'(a), 8'h00);
        chk("R1 pad_oe", {3'b0, pad_oe}, 32'h0);
        chk("R1 pad_out", {3'b0, pad_out}, 32'h0);
        chk("R1 pad_pu", {3'b0, pad_pu}, 32'h0);
        chk("R1 irq", {31'b0, evt_irq}, 32'h0);
    endtask

    task automatic t_dout();
        wr(4'h0, 8'hA5); wr(4'h4, 8'h3C); wr(4'h8, 8'h81); wr(4'hA, 8'h1F);
        rd_chk("R2 port0 dout", 4'h0, 8'hA5);
        rd_chk("R2 port1 dout", 4'h4, 8'h3C);
        rd_chk("R2 port2 dout", 4'h8, 8'h81);
        rd_chk("R2 port3 dout", 4'hA, 8'h1F);
        wr(4'hC, 8'hFF); wr(4'hD, 8'h77);
        rd_chk("R12 offset 0xC", 4'hC, 8'h00);
        rd_chk("R12 offset 0xD", 4'hD, 8'h00);
        rd_chk("R12 port0 untouched", 4'h0, 8'hA5);
        rd_chk("R12 port3 untouched", 4'hA, 8'h1F);
    endtask

    task automatic t_din();
        logic [7:0] v;
        set_pads(29'h1F_5A_C3_96);
        @(posedge clk);
        rd(4'h1, v);
        chk("R3 not visible after one edge", {24'b0, v}, 32'h0);
        @(posedge clk);
        rd_chk("R3 port0 din", 4'h1, 8'h96);
        rd_chk("R3 port1 din", 4'h5, 8'hC3);
        rd_chk("R3 port2 din", 4'h9, 8'h5A);
        set_pads(29'h1FFF_FFFF);
        repeat (2) @(posedge clk);
        rd_chk("R3 port3 bits 7:5 read 0", 4'hB, 8'h1F);
        set_pads('0);
        repeat (3) @(posedge clk);
    endtask

    task automatic t_cfg();
        wr(4'hE, 8'h15);
        rd_chk("R4 select readback", 4'hE, 8'h15);
        wr(4'hF, 8'h07);
        rd_chk("R4 cfg pin 13", 4'hF, 8'h07);
        wr(4'hF, 8'hFA);
        rd_chk("R4 cfg upper bits read 0", 4'hF, 8'h02);
        wr(4'hE, 8'h00);
        rd_chk("R4 cfg pin 0 still reset", 4'hF, 8'h00);
        wr(4'hE, 8'h15);
        wr(4'hF, 8'h00);
    endtask

    task automatic t_badsel();
        wr(4'hE, 8'h35);
        wr(4'hF, 8'h07);
        rd_chk("R5 pin 29 reads 0", 4'hF, 8'h00);
        wr(4'hE, 8'h08);
        wr(4'hF, 8'h07);
        rd_chk("R5 bit3 selector reads 0", 4'hF, 8'h00);
        wr(4'hE, 8'h40);
        wr(4'hF, 8'h07);
        rd_chk("R5 high selector reads 0", 4'hF, 8'h00);
        chk("R5 no pin enabled", {3'b0, pad_oe}, 32'h0);
        chk("R5 no pull-up set", {3'b0, pad_pu}, 32'h0);
        wr(4'hE, 8'h10);
        rd_chk("R5 pin 8 untouched", 4'hF, 8'h00);
        wr(4'hE, 8'h00);
        rd_chk("R5 pin 0 untouched", 4'hF, 8'h00);
    endtask

    task automatic t_drive();
        wr(4'hE, 8'h15);
        wr(4'hF, 8'h03);
        wr(4'h4, 8'h20);
        chk("R6 push-pull oe", {31'b0, pad_oe[13]}, 32'h1);
        chk("R6 push-pull high", {31'b0, pad_out[13]}, 32'h1);
        wr(4'h4, 8'h00);
        chk("R6 push-pull low oe", {31'b0, pad_oe[13]}, 32'h1);
        chk("R6 push-pull low", {31'b0, pad_out[13]}, 32'h0);
        wr(4'hF, 8'h01);
        chk("R7 open-drain data 0 oe", {31'b0, pad_oe[13]}, 32'h1);
        chk("R7 open-drain data 0 out", {31'b0, pad_out[13]}, 32'h0);
        wr(4'h4, 8'h20);
        chk("R7 open-drain data 1 released", {31'b0, pad_oe[13]}, 32'h0);
        chk("R7 open-drain data 1 out", {31'b0, pad_out[13]}, 32'h0);
        wr(4'hF, 8'h04);
        chk("R8 pull-up set", {31'b0, pad_pu[13]}, 32'h1);
        chk("R7 oe clear", {31'b0, pad_oe[13]}, 32'h0);
        wr(4'hF, 8'h03);
        chk("R8 pull-up clear", {31'b0, pad_pu[13]}, 32'h0);
        wr(4'hE, 8'h34);
        wr(4'hF, 8'h03);
        wr(4'hA, 8'h10);
        chk("R2 pin 28 from port3 bit4", {3'b0, pad_out}, 32'h1000_2000);
        chk("R6 oe pins 13 and 28", {3'b0, pad_oe}, 32'h1000_2000);
    endtask

    task automatic t_event();
        wr(4'h2, 8'h04);
        set_pads(29'h0000_000C);
        repeat (4) @(posedge clk);
        rd_chk("R9 enabled bit set, disabled bit not", 4'h3, 8'h04);
        chk("R11 irq with pending", {31'b0, evt_irq}, 32'h1);
        wr(4'h2, 8'h00);
        chk("R11 irq off when disabled", {31'b0, evt_irq}, 32'h0);
        rd_chk("R9 status kept while disabled", 4'h3, 8'h04);
        wr(4'h2, 8'h04);
        wr(4'h3, 8'h08);
        rd_chk("R10 zero bits unaffected", 4'h3, 8'h04);
        wr(4'h3, 8'h04);
        rd_chk("R10 write one clears", 4'h3, 8'h00);
        chk("R11 irq off after clear", {31'b0, evt_irq}, 32'h0);
        wr(4'h6, 8'h02);
        set_pads(29'h0000_020C);
        repeat (4) @(posedge clk);
        rd_chk("R9 port1 event", 4'h7, 8'h02);
        rd_chk("R9 port0 no new event", 4'h3, 8'h00);
        wr(4'h7, 8'h02);
        set_pads(29'h0000_0200);
        repeat (4) @(posedge clk);
        rd_chk("R9 falling edge sets nothing", 4'h3, 8'h00);
    endtask

    task automatic t_coincide();
        set_pads(29'h0000_0004);
        repeat (4) @(posedge clk);
        rd_chk("R9 first rise", 4'h3, 8'h04);
        set_pads(29'h0);
        repeat (4) @(posedge clk);
        set_pads(29'h0000_0004);
        @(posedge clk);
        @(posedge clk);
        wr(4'h3, 8'h04);
        rd_chk("R10 rise wins over coincident clear", 4'h3, 8'h04);
        chk("R11 irq still pending", {31'b0, evt_irq}, 32'h1);
        wr(4'h3, 8'h04);
        rd_chk("R10 later clear", 4'h3, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dout();
        t_din();
        t_cfg();
        t_badsel();
        t_drive();
        t_event();
        t_coincide();
        finish_run();
    end
endmodule